// File: doc/BRIEF.md
# Remote-Terminal Receive Buffer with Selectable Overflow Policy

This block holds received subaddress data for a remote terminal. A protocol engine writes words into it, and a host reads them out. There are two paths, and a kind bit on the write port chooses between them.

Periodic traffic goes to a two-bank (ping-pong) store. The engine always fills the hidden bank. The banks swap in a single clock edge, and only when a good end-of-message strobe arrives. An abort strobe throws away the partial message. As a result the host reads only complete messages, from the visible bank. A fresh-data flag tells the host that a swap took place, and the host clears it with an acknowledge.

Burst traffic goes to a word-wide ring queue of fixed depth. A runtime input selects what happens when a word arrives while the queue is full. Every such overflow is counted and flagged. Host pops never hold up the write side.

Top module: `term_rx_buf`

## Requirements
- R1: After reset the queue is empty (q_count 0, q_empty 1), ovf_count is 0, and ovf_flag, frozen, per_new and q_rd_valid are all 0.
- R2: A periodic word (wr_valid with wr_burst 0) goes to the next index of the hidden bank, starting at index 0. The visible bank does not change until a cycle with wr_eom high and wr_abort low. After that edge the new message is visible. per_rd_data returns the visible word at per_rd_addr one cycle after the address is presented.
- R3: A wr_abort strobe discards the partial periodic message. The previously visible message stays readable, and the next message starts again at index 0.
- R4: per_new goes to 1 on every bank swap. A per_ack pulse clears it when no swap happens in the same cycle.
- R5: Burst words come out in arrival order. A q_pop with q_count > 0 gives q_rd_valid = 1 and the head word on q_rd_data in the next cycle. q_count tracks the number of stored words.
- R6: With ovf_mode 0 (drop-new), or the reserved code 3, a push into a full queue is discarded and the stored words are unchanged.
- R7: With ovf_mode 1 (drop-old), a push into a full queue evicts the oldest word and stores the new one. q_count stays at DEPTH.
- R8: With ovf_mode 2 (freeze), a push into a full queue sets frozen. While frozen, every burst push is discarded, even after pops have made room. A frz_clr pulse leaves freeze, and pops keep working throughout.
- R9: Every burst push that is discarded or causes an eviction is an overflow event. Each event adds one to ovf_count and sets ovf_flag. An ovf_clr pulse zeroes both.
- R10: ovf_count saturates at 2^OVF_W - 1 and does not wrap.
- R11: A push and a pop in the same cycle on a full queue are both carried out, and no overflow is counted. A pop never blocks or delays a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Word strobe from the protocol engine |
| wr_burst | input | 1 | 1: word goes to the burst queue, 0: periodic store |
| wr_data | input | W | Received word |
| wr_eom | input | 1 | Periodic message completed correctly; swap banks |
| wr_abort | input | 1 | Periodic message failed; discard partial words |
| per_rd_addr | input | $clog2(MSG_WORDS) | Word index in the visible periodic bank |
| per_rd_data | output | W | Visible word, one cycle after the address |
| per_new | output | 1 | A new periodic message became visible |
| per_ack | input | 1 | Host releases the fresh-data flag |
| q_pop | input | 1 | Host takes the head word of the queue |
| q_rd_data | output | W | Popped word |
| q_rd_valid | output | 1 | q_rd_data holds a popped word this cycle |
| q_count | output | $clog2(DEPTH+1) | Words stored in the queue |
| q_empty | output | 1 | Queue holds no words |
| q_full | output | 1 | Queue holds DEPTH words |
| ovf_mode | input | 2 | 0 drop-new, 1 drop-old, 2 freeze, 3 as drop-new |
| frz_clr | input | 1 | Leave the frozen state |
| frozen | output | 1 | Queue is refusing all pushes |
| ovf_clr | input | 1 | Zero the overflow counter and flag |
| ovf_flag | output | 1 | Sticky: an overflow occurred |
| ovf_count | output | OVF_W | Saturating overflow event count |

## Verification
The queue state is registered, so q_count, ovf_count, ovf_flag and frozen change at the edge that samples a push or pop. A popped word shows up with q_rd_valid in the cycle that follows that edge. The bench drives each stimulus on a falling edge, updates a reference queue model at the rising edge, and compares all four results on the next falling edge. A periodic read is due one cycle after its address, and a swap takes effect at the edge that samples wr_eom. For that reason the bench presents the read address only after the end-of-message edge and checks the word half a cycle after the following rising edge.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  typedef enum logic [1:0] {
    OVF_DROP_NEW = 2'd0,
    OVF_DROP_OLD = 2'd1,
    OVF_FREEZE   = 2'd2,
    OVF_RSVD     = 2'd3
  } ovf_mode_e;
endpackage

// File: rtl/tbuf_pingpong.sv
module tbuf_pingpong #(
  parameter int W         = 16,
  parameter int MSG_WORDS = 4,
  localparam int IW       = $clog2(MSG_WORDS),
  localparam int SLOTS    = 2 * (1 << IW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          eom_i,
  input  logic          abort_i,
  input  logic [IW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  input  logic          ack_i,
  output logic          new_o
);
  logic [W-1:0] mem [SLOTS];
  logic         vis_bank;
  logic [IW:0]  fill_idx;
  logic         commit;

  assign commit = eom_i && !abort_i;

  // hidden bank write, extra words past MSG_WORDS are ignored
  always_ff @(posedge clk) begin
    if (wr_en_i && (fill_idx < (IW+1)'(MSG_WORDS)))
      mem[{~vis_bank, fill_idx[IW-1:0]}] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    rd_data_o <= mem[{vis_bank, rd_addr_i}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_bank <= 1'b0;
      fill_idx <= '0;
      new_o    <= 1'b0;
    end else begin
      if (abort_i || eom_i)
        fill_idx <= '0;
      else if (wr_en_i && (fill_idx < (IW+1)'(MSG_WORDS)))
        fill_idx <= fill_idx + 1'b1;
      if (commit)
        vis_bank <= ~vis_bank;
      if (commit)
        new_o <= 1'b1;
      else if (ack_i)
        new_o <= 1'b0;
    end
  end

  // R2: the visible bank flips only at a good end of message
  p_swap_at_eom_r2: assert property (@(posedge clk) disable iff (rst)
    (vis_bank != $past(vis_bank)) |-> $past(eom_i && !abort_i));

  // R3: an abort never exposes the hidden bank
  p_abort_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> $stable(vis_bank));

  // R4: fresh flag rises only with a swap
  p_new_on_swap_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(new_o) |-> (vis_bank != $past(vis_bank)));
endmodule

// File: rtl/tbuf_ring.sv
module tbuf_ring
  import tbuf_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int OVF_W = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  input  logic [1:0]       mode_i,
  input  logic             frz_clr_i,
  input  logic             ovf_clr_i,
  output logic [W-1:0]     rd_data_o,
  output logic             rd_valid_o,
  output logic [CW-1:0]    count_o,
  output logic             frozen_o,
  output logic             ovf_flag_o,
  output logic [OVF_W-1:0] ovf_count_o
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head, tail;
  ovf_mode_e     mode;
  logic          pop_ok, full, room, accept, evict, trip, ovf_evt, wr_en;

  assign mode    = ovf_mode_e'(mode_i);
  assign full    = (count_o == CW'(DEPTH));
  assign pop_ok  = pop_i && (count_o != '0);
  assign room    = !full || pop_ok;
  assign accept  = push_i && !frozen_o && room;
  assign evict   = push_i && !frozen_o && !room && (mode == OVF_DROP_OLD);
  assign trip    = push_i && !frozen_o && !room && (mode == OVF_FREEZE);
  assign ovf_evt = push_i && !accept;
  assign wr_en   = accept || evict;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[tail] <= data_i;
  end

  always_ff @(posedge clk) begin
    rd_data_o <= mem[head];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head        <= '0;
      tail        <= '0;
      count_o     <= '0;
      rd_valid_o  <= 1'b0;
      frozen_o    <= 1'b0;
      ovf_flag_o  <= 1'b0;
      ovf_count_o <= '0;
    end else begin
      rd_valid_o <= pop_ok;
      if (pop_ok || evict) head <= nxt(head);
      if (wr_en) tail <= nxt(tail);
      if (accept && !pop_ok)      count_o <= count_o + 1'b1;
      else if (pop_ok && !accept) count_o <= count_o - 1'b1;
      if (frz_clr_i)  frozen_o <= 1'b0;
      else if (trip)  frozen_o <= 1'b1;
      if (ovf_clr_i) begin
        ovf_flag_o  <= 1'b0;
        ovf_count_o <= '0;
      end else if (ovf_evt) begin
        ovf_flag_o <= 1'b1;
        if (ovf_count_o != OVF_MAX) ovf_count_o <= ovf_count_o + 1'b1;
      end
    end
  end

  // R5: occupancy never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(DEPTH));

  // R7: eviction keeps the queue full
  p_drop_old_full_r7: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && !pop_i && !frozen_o && mode_i == 2'd1) |=> (count_o == CW'(DEPTH)));

  // R8: no word enters while frozen
  p_frozen_no_grow_r8: assert property (@(posedge clk) disable iff (rst)
    (frozen_o && !frz_clr_i) |=> (count_o <= $past(count_o)));

  // R10: counter holds at its ceiling
  p_ovf_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_count_o == OVF_MAX && !ovf_clr_i) |=> (ovf_count_o == OVF_MAX));

  // R11: a simultaneous pop leaves no overflow
  p_pop_push_full_r11: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && pop_i && !frozen_o && !ovf_clr_i) |=> $stable(ovf_count_o));
endmodule

// File: rtl/term_rx_buf.sv
module term_rx_buf #(
  parameter int W         = 16,
  parameter int MSG_WORDS = 4,
  parameter int DEPTH     = 8,
  parameter int OVF_W     = 4,
  localparam int IW       = $clog2(MSG_WORDS),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic             wr_burst,
  input  logic [W-1:0]     wr_data,
  input  logic             wr_eom,
  input  logic             wr_abort,
  input  logic [IW-1:0]    per_rd_addr,
  output logic [W-1:0]     per_rd_data,
  output logic             per_new,
  input  logic             per_ack,
  input  logic             q_pop,
  output logic [W-1:0]     q_rd_data,
  output logic             q_rd_valid,
  output logic [CW-1:0]    q_count,
  output logic             q_empty,
  output logic             q_full,
  input  logic [1:0]       ovf_mode,
  input  logic             frz_clr,
  output logic             frozen,
  input  logic             ovf_clr,
  output logic             ovf_flag,
  output logic [OVF_W-1:0] ovf_count
);
  tbuf_pingpong #(.W(W), .MSG_WORDS(MSG_WORDS)) u_per (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_valid && !wr_burst),
    .wr_data_i (wr_data),
    .eom_i     (wr_eom),
    .abort_i   (wr_abort),
    .rd_addr_i (per_rd_addr),
    .rd_data_o (per_rd_data),
    .ack_i     (per_ack),
    .new_o     (per_new)
  );

  tbuf_ring #(.W(W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_ring (
    .clk         (clk),
    .rst         (rst),
    .push_i      (wr_valid && wr_burst),
    .data_i      (wr_data),
    .pop_i       (q_pop),
    .mode_i      (ovf_mode),
    .frz_clr_i   (frz_clr),
    .ovf_clr_i   (ovf_clr),
    .rd_data_o   (q_rd_data),
    .rd_valid_o  (q_rd_valid),
    .count_o     (q_count),
    .frozen_o    (frozen),
    .ovf_flag_o  (ovf_flag),
    .ovf_count_o (ovf_count)
  );

  assign q_empty = (q_count == '0);
  assign q_full  = (q_count == CW'(DEPTH));

  // R9: the flag is set whenever the counter moves up
  p_flag_with_count_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_count > $past(ovf_count)) |-> ovf_flag);
endmodule

// File: tb/term_rx_buf_tb.sv
module term_rx_buf_tb;
  localparam int W = 16, MSG_WORDS = 4, DEPTH = 8, OVF_W = 4;
  localparam int IW = $clog2(MSG_WORDS), CW = $clog2(DEPTH + 1);
  localparam int OVF_MAX = (1 << OVF_W) - 1;

  logic clk = 0, rst = 1;
  logic wr_valid = 0, wr_burst = 0, wr_eom = 0, wr_abort = 0;
  logic [W-1:0] wr_data = '0;
  logic [IW-1:0] per_rd_addr = '0;
  logic [W-1:0] per_rd_data, q_rd_data;
  logic per_new, per_ack = 0, q_pop = 0, q_rd_valid, q_empty, q_full;
  logic [CW-1:0] q_count;
  logic [1:0] ovf_mode = 2'd0;
  logic frz_clr = 0, frozen, ovf_clr = 0, ovf_flag;
  logic [OVF_W-1:0] ovf_count;

  int checks = 0, errors = 0;
  logic [W-1:0] mq[$];
  int  m_ovf = 0;
  bit  m_flag = 0, m_frz = 0;

  always #10 clk = ~clk;

  term_rx_buf #(.W(W), .MSG_WORDS(MSG_WORDS), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd1:    return "R7 drop-old";
      2'd2:    return "R8 freeze";
      default: return "R6 drop-new";
    endcase
  endfunction

  task automatic note_ovf();
    if (m_ovf < OVF_MAX) m_ovf++;
    m_flag = 1;
  endtask

  // one queue cycle: drive at falling edge, model at rising edge, check at next falling edge
  task automatic qstep(input bit push, input logic [W-1:0] d, input bit pop);
    bit full, pop_ok, popped;
    logic [W-1:0] expd;
    wr_valid = push; wr_burst = 1; wr_data = d; q_pop = pop;
    @(posedge clk);
    full   = (mq.size() == DEPTH);
    pop_ok = pop && (mq.size() > 0);
    popped = pop_ok;
    expd   = '0;
    if (pop_ok) expd = mq.pop_front();
    if (push) begin
      if (m_frz) note_ovf();
      else if (!full || pop_ok) mq.push_back(d);
      else if (ovf_mode == 2'd1) begin void'(mq.pop_front()); mq.push_back(d); note_ovf(); end
      else if (ovf_mode == 2'd2) begin m_frz = 1; note_ovf(); end
      else note_ovf();
    end
    @(negedge clk);
    wr_valid = 0; q_pop = 0;
    chk({mode_tag(ovf_mode), " R5 q_count"}, 32'(q_count), 32'(mq.size()));
    chk("R9 ovf_count", 32'(ovf_count), 32'(m_ovf));
    chk("R9 ovf_flag", 32'(ovf_flag), 32'(m_flag));
    chk("R8 frozen", 32'(frozen), 32'(m_frz));
    chk("R5 q_rd_valid", 32'(q_rd_valid), 32'(popped));
    if (popped) chk({mode_tag(ovf_mode), " R5 pop data"}, 32'(q_rd_data), 32'(expd));
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(posedge clk); @(negedge clk); s = 0;
  endtask

  task automatic clr_ovf();
    pulse(ovf_clr); m_ovf = 0; m_flag = 0;
  endtask

  task automatic pword(input logic [W-1:0] d);
    wr_valid = 1; wr_burst = 0; wr_data = d;
    @(posedge clk); @(negedge clk); wr_valid = 0;
  endtask

  task automatic pread(input int a, input logic [W-1:0] exp, input string tag);
    per_rd_addr = IW'(a);
    @(posedge clk); @(negedge clk);
    chk(tag, 32'(per_rd_data), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 q_count", 32'(q_count), 0);
    chk("R1 q_empty", 32'(q_empty), 1);
    chk("R1 ovf_count", 32'(ovf_count), 0);
    chk("R1 ovf_flag", 32'(ovf_flag), 0);
    chk("R1 frozen", 32'(frozen), 0);
    chk("R1 per_new", 32'(per_new), 0);
    chk("R1 q_rd_valid", 32'(q_rd_valid), 0);

    // R2 periodic message A
    for (int i = 0; i < MSG_WORDS; i++) pword(16'hA000 + 16'(i));
    pulse(wr_eom);
    chk("R4 per_new after swap", 32'(per_new), 1);
    for (int i = 0; i < MSG_WORDS; i++) pread(i, 16'hA000 + 16'(i), "R2 msg A visible");
    // R2 hidden update does not show before end of message
    for (int i = 0; i < MSG_WORDS; i++) pword(16'hB000 + 16'(i));
    for (int i = 0; i < MSG_WORDS; i++) pread(i, 16'hA000 + 16'(i), "R2 old kept before eom");
    pulse(per_ack);
    chk("R4 per_ack clears", 32'(per_new), 0);
    pulse(wr_eom);
    chk("R4 per_new second swap", 32'(per_new), 1);
    for (int i = 0; i < MSG_WORDS; i++) pread(i, 16'hB000 + 16'(i), "R2 msg B visible");
    pulse(per_ack);
    // R3 abort keeps previous, restarts index
    pword(16'hC000); pword(16'hC001);
    pulse(wr_abort);
    chk("R3 no fresh flag on abort", 32'(per_new), 0);
    for (int i = 0; i < MSG_WORDS; i++) pread(i, 16'hB000 + 16'(i), "R3 previous kept");
    for (int i = 0; i < MSG_WORDS; i++) pword(16'hD000 + 16'(i));
    pulse(wr_eom);
    for (int i = 0; i < MSG_WORDS; i++) pread(i, 16'hD000 + 16'(i), "R3 index restarted");

    // R6 random traffic in drop-new
    ovf_mode = 2'd0;
    for (int i = 0; i < 300; i++) qstep($urandom_range(0, 99) < 60, 16'($urandom), $urandom_range(0, 99) < 40);
    // R6 directed: fill, overflow twice, drain in order
    while (mq.size() > 0) qstep(0, 0, 1);
    clr_ovf();
    for (int i = 0; i < DEPTH + 2; i++) qstep(1, 16'h6000 + 16'(i), 0);
    chk("R6 full flag", 32'(q_full), 1);
    // R11 push and pop together on a full queue
    qstep(1, 16'h6B00, 1);
    while (mq.size() > 0) qstep(0, 0, 1);
    // reserved code behaves as drop-new
    ovf_mode = 2'd3;
    for (int i = 0; i < DEPTH + 1; i++) qstep(1, 16'h3300 + 16'(i), 0);
    while (mq.size() > 0) qstep(0, 0, 1);

    // R7 drop-old directed then random
    ovf_mode = 2'd1;
    for (int i = 0; i < DEPTH + 3; i++) qstep(1, 16'h7000 + 16'(i), 0);
    while (mq.size() > 0) qstep(0, 0, 1);
    for (int i = 0; i < 300; i++) qstep($urandom_range(0, 99) < 65, 16'($urandom), $urandom_range(0, 99) < 35);
    while (mq.size() > 0) qstep(0, 0, 1);

    // R8 freeze
    clr_ovf();
    chk("R9 ovf_clr zeroes count", 32'(ovf_count), 0);
    chk("R9 ovf_clr zeroes flag", 32'(ovf_flag), 0);
    ovf_mode = 2'd2;
    for (int i = 0; i < DEPTH + 1; i++) qstep(1, 16'h8000 + 16'(i), 0);
    qstep(0, 0, 1);
    qstep(1, 16'h8F00, 0);
    qstep(1, 16'h8F01, 0);
    pulse(frz_clr); m_frz = 0;
    chk("R8 frz_clr leaves freeze", 32'(frozen), 0);
    qstep(1, 16'h8E00, 0);
    while (mq.size() > 0) qstep(0, 0, 1);

    // R10 saturation
    ovf_mode = 2'd0;
    for (int i = 0; i < DEPTH; i++) qstep(1, 16'(i), 0);
    for (int i = 0; i < OVF_MAX + 5; i++) qstep(1, 16'hEEEE, 0);
    chk("R10 ovf_count saturated", 32'(ovf_count), 32'(OVF_MAX));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule